// File: doc/BRIEF.md
# Synchronous Phase-Frequency Detector with Three-State Pump Command

This block compares the timing of two clock-like inputs, a reference and a divided feedback clock, and tells a downstream charge pump which way to push the loop control level. Both inputs are asynchronous to the fast system clock. Each passes through a two-flop synchronizer, and a rising edge is seen on the cycle the synchronized level is 1 after being 0 on the cycle before. Falling edges are never acted on.

A three-state controller stands in for the classic pair of edge flags with a mutual clear. `ST_IDLE` means neither flag is set. `ST_LEAD_REF` means only the reference flag is set, so the pump is told to source charge. `ST_LEAD_FB` means only the feedback flag is set, so the pump is told to sink charge. The transitions are named as follows:
- `T_REF_LEADS` (idle to lead_ref) fires on a reference edge alone.
- `T_FB_LEADS` (idle to lead_fb) fires on a feedback edge alone.
- `T_FB_CATCHES` (lead_ref to idle) fires on a feedback edge.
- `T_REF_CATCHES` (lead_fb to idle) fires on a reference edge.
- `T_BOTH_SAME` (idle to idle) fires when both edges land in one cycle.

Every return to idle closes a pulse. A width meter then reports that pulse's length in system cycles, with a one-cycle strobe and a direction bit.

Top module: `pfd_pump`

## Requirements
- R1: While rst_n is low at a clock edge, every register clears. After that edge, pump_cmd is 00, pw_valid is 0, pw_count is 0 and pw_is_down is 0.
- R2: An input rise first sampled at clock edge N is acted on at edge N+2. From hold, pump_cmd changes after edge N+2.
- R3: From hold, a reference rise alone sets pump_cmd to 01 (source charge). The command stays 01 until a feedback rise is detected. Further reference rises leave it at 01.
- R4: From hold, a feedback rise alone sets pump_cmd to 10 (sink charge). The command stays 10 until a reference rise is detected. Further feedback rises leave it at 10.
- R5: A feedback rise detected while pump_cmd is 01, or a reference rise detected while it is 10, returns pump_cmd to 00 (hold) on that edge. The command never moves directly between 01 and 10.
- R6: When reference and feedback rises are detected in the same cycle from hold, pump_cmd stays 00 and no width report is made.
- R7: pump_cmd never shows 11.
- R8: Falling edges on either input have no effect on pump_cmd.
- R9: After pump_cmd has been 01 or 10 for W consecutive cycles, pw_valid is high for exactly the first cycle of hold. In that cycle pw_count is W, and pw_is_down is 0 for a source pulse and 1 for a sink pulse. pw_count and pw_is_down keep their values until the next report.
- R10: A pulse longer than 65535 cycles is reported as 65535, the saturated value of the 16-bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both compared inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference input, asynchronous |
| fb_in | input | 1 | Divided feedback clock, asynchronous |
| pump_cmd | output | 2 | 00 hold (high impedance), 01 source, 10 sink |
| pw_valid | output | 1 | One-cycle strobe marking a finished pulse |
| pw_count | output | 16 | Length of the finished pulse in system cycles, saturating |
| pw_is_down | output | 1 | 1 when the finished pulse was a sink pulse |

## Verification
A wrong controller state shows on pump_cmd in the cycle after the faulty transition. That is two clock edges after the input edge that caused it. A flag left set, or cleared too early, also shifts the width report, which lands in the first hold cycle with a count one off or a wrong direction bit. Synchronizer depth errors move every command change by whole cycles, so a cycle-by-cycle comparison catches them at the first edge. A counter fault shows only at the close of a pulse, or after 65535 cycles for the saturation path.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        PUMP_HOLD = 2'b00,
        PUMP_UP   = 2'b01,
        PUMP_DN   = 2'b10
    } pump_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_LEAD_REF = 2'b01,
        ST_LEAD_FB  = 2'b10
    } pfd_state_e;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);

    // chain_q[0..STAGES-1] synchronize, chain_q[STAGES] is the previous level
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], sig_in};
        end
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/pfd_flag_fsm.sv
module pfd_flag_fsm
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_rise,
    input  logic      fb_rise,
    output pump_cmd_e cmd_o,
    output logic      active_o,
    output logic      lead_fb_o,
    output logic      close_o
);

    pfd_state_e state_q;
    pfd_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        close_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_rise && !fb_rise) begin
                    state_d = ST_LEAD_REF;          // T_REF_LEADS
                end else if (fb_rise && !ref_rise) begin
                    state_d = ST_LEAD_FB;           // T_FB_LEADS
                end                                 // T_BOTH_SAME: stay
            end
            ST_LEAD_REF: begin
                if (fb_rise) begin
                    state_d = ST_IDLE;              // T_FB_CATCHES
                    close_o = 1'b1;
                end
            end
            ST_LEAD_FB: begin
                if (ref_rise) begin
                    state_d = ST_IDLE;              // T_REF_CATCHES
                    close_o = 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_LEAD_REF: cmd_o = PUMP_UP;
            ST_LEAD_FB:  cmd_o = PUMP_DN;
            default:     cmd_o = PUMP_HOLD;
        endcase
        active_o  = (state_q != ST_IDLE);
        lead_fb_o = (state_q == ST_LEAD_FB);
    end

endmodule

// File: rtl/pfd_width_meter.sv
module pfd_width_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             lead_fb_i,
    input  logic             close_i,
    output logic             pw_valid_o,
    output logic [CNT_W-1:0] pw_count_o,
    output logic             pw_is_down_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_inc;

    assign run_inc = (run_q == CNT_MAX) ? CNT_MAX : run_q + 1'b1;

    // running count of cycles already spent in the active state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (close_i || !active_i) begin
            run_q <= '0;
        end else begin
            run_q <= run_inc;
        end
    end

    // report latched at the closing edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_valid_o   <= 1'b0;
            pw_count_o   <= '0;
            pw_is_down_o <= 1'b0;
        end else begin
            pw_valid_o <= close_i;
            if (close_i) begin
                pw_count_o   <= run_inc;
                pw_is_down_o <= lead_fb_i;
            end
        end
    end

endmodule

// File: rtl/pfd_pump.sv
module pfd_pump
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    output logic [1:0]       pump_cmd,
    output logic             pw_valid,
    output logic [CNT_W-1:0] pw_count,
    output logic             pw_is_down
);

    localparam int NUM_CHAN = 2;   // index 0 reference, 1 feedback

    logic [NUM_CHAN-1:0] raw_in;
    logic [NUM_CHAN-1:0] rise;
    pump_cmd_e           cmd;
    logic                active;
    logic                lead_fb;
    logic                close_evt;

    assign raw_in = {fb_in, ref_in};

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        pfd_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (raw_in[g]),
            .rise_o (rise[g])
        );
    end

    pfd_flag_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise  (rise[0]),
        .fb_rise   (rise[1]),
        .cmd_o     (cmd),
        .active_o  (active),
        .lead_fb_o (lead_fb),
        .close_o   (close_evt)
    );

    pfd_width_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (active),
        .lead_fb_i    (lead_fb),
        .close_i      (close_evt),
        .pw_valid_o   (pw_valid),
        .pw_count_o   (pw_count),
        .pw_is_down_o (pw_is_down)
    );

    assign pump_cmd = cmd;

endmodule

// File: rtl/pfd_pump_chk.sv
module pfd_pump_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       pump_cmd,
    input logic             pw_valid,
    input logic [CNT_W-1:0] pw_count,
    input logic             pw_is_down
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pump_cmd == 2'b00 && !pw_valid && pw_count == '0));

    // R7
    no_code3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_cmd != 2'b11);

    // R5
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pump_cmd) != 2'b00 && pump_cmd != $past(pump_cmd)) |-> pump_cmd == 2'b00);

    // R9
    strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |=> !pw_valid);

    // R9
    strobe_first_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |-> (pump_cmd == 2'b00 && $past(pump_cmd) != 2'b00));

    // R9
    strobe_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |-> (pw_is_down == ($past(pump_cmd) == 2'b10)));

    // R9
    width_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pw_valid |-> pw_count != '0);

    // R6
    hold_to_hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pump_cmd) == 2'b00 && pump_cmd == 2'b00 && $past(pw_valid)) |-> !pw_valid);

endmodule

bind pfd_pump pfd_pump_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pump_cmd   (pump_cmd),
    .pw_valid   (pw_valid),
    .pw_count   (pw_count),
    .pw_is_down (pw_is_down)
);

// File: tb/pfd_pump_tb.sv
`timescale 1ns/1ps
module pfd_pump_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        fb_in = 1'b0;
    logic [1:0]  pump_cmd;
    logic        pw_valid;
    logic [15:0] pw_count;
    logic        pw_is_down;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // model of the requirements
    bit m_r1, m_r2, m_r3, m_f1, m_f2, m_f3;
    int m_st = 0;
    int m_cnt = 0;
    bit m_pwv = 0;
    int m_pwc = 0;
    bit m_pwd = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    pfd_pump u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .pump_cmd(pump_cmd), .pw_valid(pw_valid), .pw_count(pw_count),
        .pw_is_down(pw_is_down)
    );

    function automatic int sat16(input int v);
        return (v > 65535) ? 65535 : v;
    endfunction

    task automatic model_step();
        bit re, fe, cl;
        int nx;
        if (!rst_n) begin
            {m_r1, m_r2, m_r3, m_f1, m_f2, m_f3} = '0;
            m_st = 0; m_cnt = 0; m_pwv = 0; m_pwc = 0; m_pwd = 0;
            return;
        end
        re = m_r2 & ~m_r3;  // R2 two-flop sync then edge
        fe = m_f2 & ~m_f3;
        nx = m_st; cl = 0;
        case (m_st)
            0: if (re && !fe) nx = 1; else if (fe && !re) nx = 2;   // R3 R4 R6
            1: if (fe) begin nx = 0; cl = 1; end                     // R5
            2: if (re) begin nx = 0; cl = 1; end                     // R5
            default: nx = 0;
        endcase
        m_pwv = cl;
        if (cl) begin m_pwc = sat16(m_cnt + 1); m_pwd = (m_st == 2); end  // R9 R10
        m_cnt = (m_st != 0 && !cl) ? sat16(m_cnt + 1) : 0;
        m_st = nx;
        m_r3 = m_r2; m_r2 = m_r1; m_r1 = ref_in;
        m_f3 = m_f2; m_f2 = m_f1; m_f1 = fb_in;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one cycle: step the model, compare all outputs against it
    task automatic tick();
        @(negedge clk);
        cyc++;
        model_step();
        check("R4", "pump_cmd vs model", int'(pump_cmd), m_st);
        check("R9", "pw_valid vs model", int'(pw_valid), int'(m_pwv));
        check("R9", "pw_count vs model", int'(pw_count), m_pwc);
        check("R9", "pw_is_down vs model", int'(pw_is_down), int'(m_pwd));
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        ticks(3);
        rst_n = 1'b1;
        ticks(4);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        wait (cyc > 190000);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        report();
    end

    initial begin
        void'($urandom(32'd20251));

        // R1: reset state
        rst_n = 1'b0; ticks(3);
        check("R1", "cmd in reset", int'(pump_cmd), 0);
        check("R1", "valid in reset", int'(pw_valid), 0);
        check("R1", "count in reset", int'(pw_count), 0);
        check("R1", "sign in reset", int'(pw_is_down), 0);
        rst_n = 1'b1; ticks(4);

        // R2 and R3: latency of a lone reference rise
        ref_in = 1'b1;
        tick(); tick();
        check("R2", "cmd before edge N+2", int'(pump_cmd), 0);
        tick();
        check("R3", "cmd after ref leads", int'(pump_cmd), 1);
        // R8: falling reference has no effect
        ref_in = 1'b0; ticks(4);
        check("R8", "cmd after ref falls", int'(pump_cmd), 1);
        // R3: another reference rise while up is ignored
        ref_in = 1'b1; ticks(4);
        check("R3", "cmd after second ref rise", int'(pump_cmd), 1);
        // R5 and R9: feedback closes the pulse; width is 11 cycles
        fb_in = 1'b1; tick(); tick();
        check("R5", "cmd before fb acts", int'(pump_cmd), 1);
        tick();
        check("R5", "cmd after fb catches", int'(pump_cmd), 0);
        check("R9", "valid at close", int'(pw_valid), 1);
        check("R9", "width of up pulse", int'(pw_count), 11);
        check("R9", "sign of up pulse", int'(pw_is_down), 0);
        tick();
        check("R9", "valid one cycle only", int'(pw_valid), 0);
        check("R9", "width held", int'(pw_count), 11);
        ref_in = 1'b0; fb_in = 1'b0; ticks(5);

        // R4: feedback leads by 7 cycles
        fb_in = 1'b1; ticks(3);
        check("R4", "cmd after fb leads", int'(pump_cmd), 2);
        fb_in = 1'b0; ticks(2); fb_in = 1'b1; ticks(2);
        ref_in = 1'b1; ticks(3);
        check("R5", "cmd after ref catches", int'(pump_cmd), 0);
        check("R9", "width of down pulse", int'(pw_count), 7);
        check("R9", "sign of down pulse", int'(pw_is_down), 1);
        ref_in = 1'b0; fb_in = 1'b0; ticks(5);

        // R6: simultaneous rises
        ref_in = 1'b1; fb_in = 1'b1; ticks(2);
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R6", "cmd on equal edges", int'(pump_cmd), 0);
            check("R6", "no report on equal edges", int'(pw_valid), 0);
        end
        ref_in = 1'b0; fb_in = 1'b0; ticks(4);

        // R10: saturation of a very long pulse
        ref_in = 1'b1; ticks(70000);
        fb_in = 1'b1; ticks(3);
        check("R10", "saturated width", int'(pw_count), 65535);
        check("R10", "saturated report valid", int'(pw_valid), 1);
        ref_in = 1'b0; fb_in = 1'b0; ticks(4);

        // random phase and frequency patterns, R7 on every cycle
        for (int i = 0; i < 20000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 9) ref_in = ~ref_in;
            else if (r < 17) fb_in = ~fb_in;
            else if (r < 19) begin ref_in = ~ref_in; fb_in = ~fb_in; end
            if ($urandom_range(0, 1999) == 0) rst_n = 1'b0; else rst_n = 1'b1;
            tick();
            n_cmp++;
            if (pump_cmd == 2'b11) begin
                n_bad++;
                $display("FAIL R7 code: actual %0d expected not 3", pump_cmd);
            end
        end
        rst_n = 1'b1; ticks(5);

        // R1: reset in the middle of a pulse
        ref_in = 1'b0; fb_in = 1'b0; ticks(3);
        ref_in = 1'b1; ticks(5);
        rst_n = 1'b0; tick();
        check("R1", "cmd after mid-pulse reset", int'(pump_cmd), 0);
        rst_n = 1'b1; ticks(3);

        report();
    end

endmodule